// File: doc/BRIEF.md
# Sub-addressed Configuration Register Slave on a Two-Wire Serial Bus

This block is a target (slave) on an I2C bus. It gives a host controller read and write access to a small bank of 8-bit configuration registers. The host selects a register through an 8-bit sub-address pointer. A write transaction sends the sub-address first, then any number of data bytes. A read transaction sets the pointer with a short write, then issues a repeated START and the read address, and the block streams bytes out. The pointer advances after every data byte, in both directions. The 7-bit device address is one of two neighbouring values, chosen by a strap pin. SDA is only ever pulled low, through an output enable.

The register at sub-address 0x00 is a read-only identity byte equal to 0x70 plus the `VARIANT` parameter. The register at sub-address 0x01 holds three packed configuration fields, which leave the block as plain parallel outputs for the rest of the chip.

SCL and SDA are resampled on the system clock, which must run at least 8 times faster than SCL. The serial bus is the block's only data path, so it has no valid/ready port. Every other pin is a plain level: the strap is static, and the field outputs change in the cycle after the byte that writes them is complete.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The device address is 7'h20 when `addr_sel` is 0 and 7'h21 when it is 1. The address occupies the upper seven bits of the first byte after START, most significant bit first. The lowest bit of that byte is the direction: 0 for write, 1 for read. In byte form the write/read pairs are 0x40/0x41 and 0x42/0x43.
- R2: In a write frame the first byte after the address is loaded into the sub-address pointer, and every later byte is stored at the pointer. The block acknowledges the address byte and each following byte by holding SDA low through the ninth SCL pulse.
- R3: After a read address is acknowledged, the block shifts out, most significant bit first, the register at the pointer. It keeps sending the next byte for as long as the host acknowledges. A NACK from the host ends the transfer, with SDA released.
- R4: The pointer increases by one after each data byte written or read, so consecutive bytes of one frame reach consecutive sub-addresses.
- R5: Sub-address 0x00 reads as 0x70 + `VARIANT`. A write to it is acknowledged but changes nothing.
- R6: Sub-address 0x01 resets to 0x07. Its bits [7:5] drive `std_sel`, bits [4:3] drive `fmt_sel` and bits [2:0] drive `ped_sel`. The register changes only when that sub-address is written.
- R7: `std_sel` carries the written code unchanged. The meanings are 000 NTSC-M, 010 PAL-B/D/G/H/I, 011 PAL-M, 100 PAL-N and 101 PAL-Nc. The reserved codes 001, 110 and 111 are stored as written.
- R8: When the address byte does not match, the block does not acknowledge it, never drives SDA, and ignores all traffic until the next START.
- R9: Sub-addresses other than 0x00 and 0x01 read as 0x00. Writes to them are acknowledged and discarded.
- R10: A START (SDA falling while SCL is high) or a STOP (SDA rising while SCL is high) abandons any byte in progress. START returns the block to waiting for an address, and STOP returns it to idle.
- R11: SDA is driven only low, through `sda_oe`. `sda_oe` changes only while SCL is low, apart from its release at a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Strap that picks the device address |
| scl_i | input | 1 | SCL as seen on the pad |
| sda_i | input | 1 | SDA as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| std_sel | output | 3 | Timing-standard field of register 0x01 |
| fmt_sel | output | 2 | Output-format field of register 0x01 |
| ped_sel | output | 3 | Pedestal field of register 0x01 |

## Verification
The assertions watch four things on every cycle:
- `sda_oe` moves only while SCL is low or at a START or STOP.
- An ignored transaction never drives SDA.
- Every START rearms address reception.
- Each stored byte advances the pointer and leaves register 0x01 untouched unless 0x01 itself is written.

The bench's bus scenarios cover what the assertions cannot see:
- address matching under both strap values;
- the identity value and its immunity to writes;
- the field positions and reserved codes of register 0x01;
- burst reads across implemented and unimplemented sub-addresses;
- the NACK-terminated read;
- a STOP in the middle of a byte, which must leave the registers as they were.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } bus_st_e;

  localparam logic [7:0] REG_ID    = 8'h00;
  localparam logic [7:0] REG_FMT   = 8'h01;
  localparam logic [7:0] FMT_RESET = 8'h07;
  localparam logic [7:0] ID_BASE   = 8'h70;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] scl_ff, sda_ff;
  logic         scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[TOP-1:0], scl_i};
      sda_ff <= {sda_ff[TOP-1:0], sda_i};
      scl_q  <= scl_ff[TOP];
      sda_q  <= sda_ff[TOP];
    end
  end

  assign scl_s    = scl_ff[TOP];
  assign sda_s    = sda_ff[TOP];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs
  import i2c_cfg_pkg::*;
#(
  parameter int VARIANT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic [2:0] std_sel,
  output logic [1:0] fmt_sel,
  output logic [2:0] ped_sel
);
  localparam logic [7:0] ID_VAL = ID_BASE + 8'(VARIANT);

  logic [7:0] fmt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            fmt_q <= FMT_RESET;
    else if (wr_en && wr_addr == REG_FMT)  fmt_q <= wr_data;
  end

  always_comb begin
    case (rd_addr)
      REG_ID:  rd_data = ID_VAL;
      REG_FMT: rd_data = fmt_q;
      default: rd_data = 8'h00;
    endcase
  end

  assign std_sel = fmt_q[7:5];
  assign fmt_sel = fmt_q[4:3];
  assign ped_sel = fmt_q[2:0];

  AST_FMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == REG_FMT) |=> $stable(fmt_q)); // R6
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter int         VARIANT     = 2,
  parameter logic [6:0] ADDR_BASE   = 7'h20,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_sel,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [2:0] std_sel,
  output logic [1:0] fmt_sel,
  output logic [2:0] ped_sel
);
  localparam int         CNT_W  = 4;
  localparam logic [3:0] BYTE_N = 4'd8;

  logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  bus_st_e    state;
  logic [CNT_W-1:0] cnt;
  logic [7:0] shreg, ptr, rd_data;
  logic       rw_q, first_q, oe_q;
  logic       wr_en;
  logic [6:0] dev_addr;

  assign dev_addr = ADDR_BASE | {6'b0, addr_sel};

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  // a completed data byte (not the sub-address) is stored at the pointer
  assign wr_en = (state == ST_RX) && scl_fall && (cnt == BYTE_N) && !first_q;

  i2c_cfg_regs #(.VARIANT(VARIANT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr), .wr_data(shreg),
    .rd_addr(ptr), .rd_data(rd_data),
    .std_sel(std_sel), .fmt_sel(fmt_sel), .ped_sel(ped_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      ptr     <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_ev) begin
      state <= ST_ADDR;
      cnt   <= '0;
      oe_q  <= 1'b0;
    end else if (stop_ev) begin
      state <= ST_IDLE;
      cnt   <= '0;
      oe_q  <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise && cnt < BYTE_N) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == BYTE_N) begin
            if (shreg[7:1] == dev_addr) begin
              oe_q    <= 1'b1;
              rw_q    <= shreg[0];
              first_q <= ~shreg[0];
              state   <= ST_ADDR_ACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw_q) begin
              shreg <= rd_data;
              oe_q  <= ~rd_data[7];
              ptr   <= ptr + 8'd1;
              state <= ST_TX;
            end else begin
              oe_q  <= 1'b0;
              state <= ST_RX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise && cnt < BYTE_N) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == BYTE_N) begin
            oe_q  <= 1'b1;
            state <= ST_RX_ACK;
            if (first_q) begin
              ptr     <= shreg;
              first_q <= 1'b0;
            end else begin
              ptr <= ptr + 8'd1;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            oe_q  <= 1'b0;
            cnt   <= '0;
            state <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              oe_q  <= 1'b0;
              cnt   <= '0;
              state <= ST_TX_ACK;
            end else begin
              shreg <= {shreg[6:0], 1'b0};
              oe_q  <= ~shreg[6];
              cnt   <= cnt + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            if (sda_s) state <= ST_IGNORE;
            else       cnt   <= 4'd1;
          end else if (scl_fall && cnt == 4'd1) begin
            shreg <= rd_data;
            oe_q  <= ~rd_data[7];
            ptr   <= ptr + 8'd1;
            cnt   <= '0;
            state <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe_q;

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> ($past(start_ev) || $past(stop_ev) || !$past(scl_s))); // R11
  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !oe_q); // R8
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == ST_ADDR)); // R10
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == $past(ptr) + 8'd1)); // R4
endmodule

// File: tb/tb_i2c_cfg_slave.sv
module tb_i2c_cfg_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [2:0] std_sel;
  logic [1:0] fmt_sel;
  logic [2:0] ped_sel;
  wire sda_line;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_cfg_slave dut (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .std_sel(std_sel), .fmt_sel(fmt_sel), .ped_sel(ped_sel)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic quarter();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; quarter();
    sda_m = 1'b0; quarter();
    scl_m = 1'b0;
  endtask

  task automatic bus_restart();
    quarter(); sda_m = 1'b1; quarter();
    scl_m = 1'b1; quarter();
    sda_m = 1'b0; quarter();
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    quarter(); sda_m = 1'b0; quarter();
    scl_m = 1'b1; quarter();
    sda_m = 1'b1; quarter(); quarter();
  endtask

  task automatic send_bit(input logic b);
    quarter(); sda_m = b; quarter();
    scl_m = 1'b1; quarter(); quarter();
    scl_m = 1'b0;
  endtask

  task automatic read_bit(output logic b);
    quarter(); sda_m = 1'b1; quarter();
    scl_m = 1'b1; quarter();
    b = sda_line; quarter();
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    read_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      read_bit(b);
      d[i] = b;
    end
    send_bit(~mack);
  endtask

  task automatic do_write(input logic [7:0] dev, input logic [7:0] sub,
                          input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                          input int n, output logic a_addr, output logic a_all);
    logic a;
    bus_start();
    send_byte(dev, a_addr);
    send_byte(sub, a);
    a_all = a_addr & a;
    if (n > 0) begin send_byte(d0, a); a_all &= a; end
    if (n > 1) begin send_byte(d1, a); a_all &= a; end
    if (n > 2) begin send_byte(d2, a); a_all &= a; end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] dev, input logic [7:0] sub, input int n,
                         output logic [7:0] r0, output logic [7:0] r1, output logic [7:0] r2,
                         output logic a_all);
    logic a;
    bus_start();
    send_byte(dev, a_all);
    send_byte(sub, a); a_all &= a;
    bus_restart();
    send_byte(dev | 8'h01, a); a_all &= a;
    r1 = 8'h00; r2 = 8'h00;
    recv_byte(n > 1, r0);
    if (n > 1) recv_byte(n > 2, r1);
    if (n > 2) recv_byte(1'b0, r2);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R6 reset std", {5'b0, std_sel}, 8'h00);
    chk("R6 reset fmt", {6'b0, fmt_sel}, 8'h00);
    chk("R6 reset ped", {5'b0, ped_sel}, 8'h07);
    chk("R11 reset sda_oe", {7'b0, sda_oe}, 8'h00);
  endtask

  task automatic t_id_read();
    logic [7:0] r0, r1, r2; logic a;
    do_read(8'h40, 8'h00, 1, r0, r1, r2, a);
    chk("R3 read acks", {7'b0, a}, 8'h01);
    chk("R5 id value", r0, 8'h72);
    chk("R3 released after nack", {7'b0, sda_oe}, 8'h00);
  endtask

  task automatic t_fmt_write();
    logic aa, al;
    do_write(8'h40, 8'h01, 8'hA5, 8'h00, 8'h00, 1, aa, al);
    chk("R2 write acks", {7'b0, al}, 8'h01);
    chk("R6 std field", {5'b0, std_sel}, 8'h05);
    chk("R6 fmt field", {6'b0, fmt_sel}, 8'h00);
    chk("R6 ped field", {5'b0, ped_sel}, 8'h05);
    do_write(8'h40, 8'h01, 8'hF8, 8'h00, 8'h00, 1, aa, al);
    chk("R7 reserved std kept", {5'b0, std_sel}, 8'h07);
    chk("R7 fmt 11", {6'b0, fmt_sel}, 8'h03);
    chk("R7 ped 000", {5'b0, ped_sel}, 8'h00);
  endtask

  task automatic t_id_write();
    logic aa, al; logic [7:0] r0, r1, r2; logic a;
    do_write(8'h40, 8'h00, 8'h55, 8'h00, 8'h00, 1, aa, al);
    chk("R5 write to id acked", {7'b0, al}, 8'h01);
    do_read(8'h40, 8'h00, 1, r0, r1, r2, a);
    chk("R5 id unchanged", r0, 8'h72);
  endtask

  task automatic t_burst_write();
    logic aa, al;
    do_write(8'h40, 8'h00, 8'h11, 8'h4B, 8'h99, 3, aa, al);
    chk("R9 burst incl. unimplemented acked", {7'b0, al}, 8'h01);
    chk("R4 second byte reached 0x01", {std_sel, fmt_sel, ped_sel}, 8'h4B);
  endtask

  task automatic t_burst_read();
    logic [7:0] r0, r1, r2; logic a;
    do_read(8'h40, 8'h00, 3, r0, r1, r2, a);
    chk("R3 burst acks", {7'b0, a}, 8'h01);
    chk("R4 burst byte0", r0, 8'h72);
    chk("R4 burst byte1", r1, 8'h4B);
    chk("R9 unimplemented reads zero", r2, 8'h00);
    do_read(8'h40, 8'h02, 1, r0, r1, r2, a);
    chk("R9 write to 0x02 discarded", r0, 8'h00);
  endtask

  task automatic t_wrong_addr();
    logic aa, al;
    do_write(8'h44, 8'h01, 8'h00, 8'h00, 8'h00, 1, aa, al);
    chk("R8 no ack on mismatch", {7'b0, aa}, 8'h00);
    chk("R8 data ignored", {std_sel, fmt_sel, ped_sel}, 8'h4B);
  endtask

  task automatic t_strap();
    logic aa, al; logic [7:0] r0, r1, r2; logic a;
    addr_sel = 1'b1;
    do_write(8'h40, 8'h01, 8'h07, 8'h00, 8'h00, 1, aa, al);
    chk("R1 old address refused", {7'b0, aa}, 8'h00);
    chk("R1 refused write no effect", {std_sel, fmt_sel, ped_sel}, 8'h4B);
    do_write(8'h42, 8'h01, 8'h63, 8'h00, 8'h00, 1, aa, al);
    chk("R1 strap address acked", {7'b0, al}, 8'h01);
    chk("R1 strap write landed", {std_sel, fmt_sel, ped_sel}, 8'h63);
    do_read(8'h42, 8'h00, 1, r0, r1, r2, a);
    chk("R1 strap read", {r0[6:0], a}, {7'h72, 1'b1});
  endtask

  task automatic t_abort();
    logic a, aa, al;
    bus_start();
    send_byte(8'h42, a);
    send_byte(8'h01, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    chk("R10 aborted byte dropped", {std_sel, fmt_sel, ped_sel}, 8'h63);
    chk("R10 sda released", {7'b0, sda_oe}, 8'h00);
    do_write(8'h42, 8'h01, 8'h2E, 8'h00, 8'h00, 1, aa, al);
    chk("R10 next frame works", {std_sel, fmt_sel, ped_sel}, 8'h2E);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_id_read();
    t_fmt_write();
    t_id_write();
    t_burst_write();
    t_burst_read();
    t_wrong_addr();
    t_strap();
    t_abort();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule